// File: doc/BRIEF.md
# Tile Program Sequencer

The sequencer walks a short program held in an external instruction store and drives the rest of a small tensor core from it. Each instruction is fetched from the address in the program counter and decoded in the same cycle. It then runs through a few execute states. In those states the sequencer moves 4x4 tiles of signed 32-bit words between a 16-tile scratchpad and a 16-entry register file, hands tile operations to a vector unit, and fills tiles from an immediate, from one row or from one column.

Matrix jobs are asynchronous. A dispatch instruction pulses a start strobe carrying two base addresses and a length, and the program then carries on at once. A separate wait instruction parks only the sequencer until the matrix unit reports completion. A later instruction copies the finished result tile into a register. A pulse on `start` runs the program from address zero. A halt instruction parks the block with a status flag raised.

Top module: `tile_sequencer`

## Requirements
- R1: While reset is held, and after it until the first `start` pulse, the block raises no scratchpad request, register write, vector request or matrix start, and `halted` is low.
- R2: A `start` pulse sets the program counter to 0, and the next cycle fetches address 0. Every fetched instruction other than halt advances the counter by one. The 24-bit instruction word holds the opcode in [23:20] and the fields A [19:16], B [15:12], C [11:8] and D [7:4]; bits [3:0] are spare. The opcodes are: 0 load, 1 store, 2 vector op, 3 select, 4 fill scalar, 5 fill row, 6 fill column, 7 matrix dispatch, 8 matrix wait, 9 matrix result, 10 halt.
- R3: A load copies scratchpad tile B into register A. It takes three cycles: the fetch, a read request, and the response cycle, which writes the register.
- R4: A store writes register B into scratchpad tile A. It takes two cycles: the fetch and a single write request.
- R5: A vector op sends registers B and C, with operation code D, to the vector unit. It waits for the response and writes the response tile to register A in the response cycle.
- R6: A select sends register B as the condition, register C as the true operand and register D as the false operand, with the select flag raised. The response is written to register A.
- R7: Fill scalar writes every element of register A with the sign-extended 16-bit immediate held in bits [15:0]. It takes two cycles.
- R8: Fill row writes register A so that every row equals row C of register B. Element (row r, lane c) of a tile sits at bits 32*(4r+c).
- R9: Fill column writes register A so that every lane equals lane C of register B.
- R10: Matrix dispatch pulses `mxu_start` for exactly one cycle, carrying weight base A, activation base B and length C. The next fetch follows at once, without waiting for the job.
- R11: Matrix wait stalls only while a dispatched job has not yet reported done. A done pulse that arrives before the wait, or in the first wait cycle, lets the wait finish in two cycles.
- R12: Matrix result copies the `mxu_result` tile into register A in two cycles.
- R13: Halt raises `halted`. The block then fetches no further instructions and writes no registers until the next `start` pulse.
- R14: Opcodes 11 to 15 take one fetch cycle, write nothing, and advance the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Restart the program from address 0 |
| imem_addr | output | PC_W | Instruction store address |
| imem_data | input | 24 | Instruction word at `imem_addr` |
| sp_req_valid | output | 1 | Scratchpad request |
| sp_req_write | output | 1 | Request is a write |
| sp_req_addr | output | 4 | Scratchpad tile index |
| sp_req_wdata | output | 512 | Tile to write |
| sp_rsp_data | input | 512 | Read tile, one cycle after the request |
| rf_rd_addr_a | output | 4 | Register read port A (field B) |
| rf_rd_addr_b | output | 4 | Register read port B (field C) |
| rf_rd_addr_c | output | 4 | Register read port C (field D) |
| rf_rd_data_a | input | 512 | Read data A |
| rf_rd_data_b | input | 512 | Read data B |
| rf_rd_data_c | input | 512 | Read data C |
| rf_wr_en | output | 1 | Register write enable |
| rf_wr_addr | output | 4 | Register write index |
| rf_wr_data | output | 512 | Register write tile |
| vpu_req_valid | output | 1 | Vector request, one cycle |
| vpu_req_select | output | 1 | Request is a select |
| vpu_req_op | output | 4 | Vector operation code |
| vpu_src_a | output | 512 | First operand or condition |
| vpu_src_b | output | 512 | Second operand or true operand |
| vpu_src_c | output | 512 | False operand |
| vpu_rsp_valid | input | 1 | Vector result valid |
| vpu_rsp_data | input | 512 | Vector result tile |
| mxu_start | output | 1 | Matrix job start pulse |
| mxu_w_base | output | 4 | Weight base |
| mxu_a_base | output | 4 | Activation base |
| mxu_len | output | 4 | Tile length |
| mxu_done | input | 1 | Matrix job done pulse |
| mxu_result | input | 512 | Matrix result tile |
| halted | output | 1 | Program has halted |

## Verification
The delicate overlap is the matrix done pulse landing in the same cycle as the wait instruction's fetch, or in its first wait cycle. In both cases the outstanding flag must clear and the wait must still finish. The bench provokes this by running a dispatch, then zero to two filler instructions, then a wait. It sweeps the stub matrix latency from 1 to 6 so the done pulse lands before, inside and after the wait. Each run is judged by counting the cycles from start to halt against a latency formula worked out in the bench, and by the result tile written to the register file.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
    parameter int LANES    = 4;
    parameter int SUBLANES = 4;
    parameter int ELEM_W   = 32;
    parameter int FIELD_W  = 4;
    parameter int OPC_W    = 4;
    parameter int IMM_W    = 16;

    localparam int TILE_W  = LANES * SUBLANES * ELEM_W;
    localparam int INSTR_W = OPC_W + 5 * FIELD_W;
    localparam int ROW_IW  = $clog2(SUBLANES);
    localparam int COL_IW  = $clog2(LANES);

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD   = 4'd0,
        OP_STORE  = 4'd1,
        OP_VEC    = 4'd2,
        OP_SELECT = 4'd3,
        OP_FILL_S = 4'd4,
        OP_FILL_R = 4'd5,
        OP_FILL_C = 4'd6,
        OP_MX_GO  = 4'd7,
        OP_MX_WAIT= 4'd8,
        OP_MX_RES = 4'd9,
        OP_HALT   = 4'd10
    } opcode_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FETCH, ST_SP_REQ, ST_SP_RSP,
        ST_VEC_EXEC, ST_VEC_RES, ST_EXEC, ST_WAIT, ST_HALT
    } state_e;

    typedef struct packed {
        logic [OPC_W-1:0]   opc;
        logic [FIELD_W-1:0] fa;
        logic [FIELD_W-1:0] fb;
        logic [FIELD_W-1:0] fc;
        logic [FIELD_W-1:0] fd;
        logic [FIELD_W-1:0] fe;
    } instr_t;

    localparam logic [1:0] FILL_SCALAR = 2'd0;
    localparam logic [1:0] FILL_ROW    = 2'd1;
    localparam logic [1:0] FILL_COL    = 2'd2;
endpackage

// File: rtl/tseq_bcast.sv
module tseq_bcast
    import tseq_pkg::*;
(
    input  logic [TILE_W-1:0] src,
    input  logic [1:0]        mode,
    input  logic [ROW_IW-1:0] row_idx,
    input  logic [COL_IW-1:0] col_idx,
    input  logic [ELEM_W-1:0] scalar,
    output logic [TILE_W-1:0] dst
);
    logic [ELEM_W-1:0] elem [SUBLANES][LANES];

    for (genvar r = 0; r < SUBLANES; r++) begin : g_row
        for (genvar c = 0; c < LANES; c++) begin : g_lane
            localparam int BASE = (r * LANES + c) * ELEM_W;
            assign elem[r][c] = src[BASE +: ELEM_W];
            assign dst[BASE +: ELEM_W] =
                (mode == FILL_ROW) ? elem[row_idx][c] :
                (mode == FILL_COL) ? elem[r][col_idx] : scalar;
        end
    end
endmodule

// File: rtl/tseq_mxu_track.sv
module tseq_mxu_track (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic done,
    output logic busy
);
    logic busy_d, busy_q;

    always_comb begin
        busy_d = busy_q;
        if (done)   busy_d = 1'b0;
        if (launch) busy_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy_d;
    end

    assign busy = busy_q;

    AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);                                             // R11
    AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !launch) |=> !busy);                                 // R11
endmodule

// File: rtl/tile_sequencer.sv
module tile_sequencer
    import tseq_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    output logic [PC_W-1:0]     imem_addr,
    input  logic [INSTR_W-1:0]  imem_data,
    output logic                sp_req_valid,
    output logic                sp_req_write,
    output logic [FIELD_W-1:0]  sp_req_addr,
    output logic [TILE_W-1:0]   sp_req_wdata,
    input  logic [TILE_W-1:0]   sp_rsp_data,
    output logic [FIELD_W-1:0]  rf_rd_addr_a,
    output logic [FIELD_W-1:0]  rf_rd_addr_b,
    output logic [FIELD_W-1:0]  rf_rd_addr_c,
    input  logic [TILE_W-1:0]   rf_rd_data_a,
    input  logic [TILE_W-1:0]   rf_rd_data_b,
    input  logic [TILE_W-1:0]   rf_rd_data_c,
    output logic                rf_wr_en,
    output logic [FIELD_W-1:0]  rf_wr_addr,
    output logic [TILE_W-1:0]   rf_wr_data,
    output logic                vpu_req_valid,
    output logic                vpu_req_select,
    output logic [FIELD_W-1:0]  vpu_req_op,
    output logic [TILE_W-1:0]   vpu_src_a,
    output logic [TILE_W-1:0]   vpu_src_b,
    output logic [TILE_W-1:0]   vpu_src_c,
    input  logic                vpu_rsp_valid,
    input  logic [TILE_W-1:0]   vpu_rsp_data,
    output logic                mxu_start,
    output logic [FIELD_W-1:0]  mxu_w_base,
    output logic [FIELD_W-1:0]  mxu_a_base,
    output logic [FIELD_W-1:0]  mxu_len,
    input  logic                mxu_done,
    input  logic [TILE_W-1:0]   mxu_result,
    output logic                halted
);
    typedef struct packed {
        state_e            st;
        logic [PC_W-1:0]   pc;
        instr_t            ir;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    instr_t    fetched;
    logic      mx_busy;
    logic      is_fill, is_fill_wr;
    logic [1:0]         fill_mode;
    logic [IMM_W-1:0]   imm;
    logic [ELEM_W-1:0]  imm_ext;
    logic [TILE_W-1:0]  fill_tile;

    assign fetched = instr_t'(imem_data);

    // next-state computation
    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_FETCH: begin
                seq_d.ir = fetched;
                if (fetched.opc != OP_HALT) seq_d.pc = seq_q.pc + 1'b1;
                case (fetched.opc)
                    OP_HALT:                       seq_d.st = ST_HALT;
                    OP_LOAD, OP_STORE:             seq_d.st = ST_SP_REQ;
                    OP_VEC, OP_SELECT:             seq_d.st = ST_VEC_EXEC;
                    OP_FILL_S, OP_FILL_R, OP_FILL_C,
                    OP_MX_GO, OP_MX_RES:           seq_d.st = ST_EXEC;
                    OP_MX_WAIT:                    seq_d.st = ST_WAIT;
                    default:                       seq_d.st = ST_FETCH;
                endcase
            end
            ST_SP_REQ:   seq_d.st = (seq_q.ir.opc == OP_LOAD) ? ST_SP_RSP : ST_FETCH;
            ST_SP_RSP:   seq_d.st = ST_FETCH;
            ST_VEC_EXEC: seq_d.st = ST_VEC_RES;
            ST_VEC_RES:  if (vpu_rsp_valid) seq_d.st = ST_FETCH;
            ST_EXEC:     seq_d.st = ST_FETCH;
            ST_WAIT:     if (!mx_busy || mxu_done) seq_d.st = ST_FETCH;
            default:     seq_d.st = seq_q.st;
        endcase
        if (start) begin
            seq_d.st = ST_FETCH;
            seq_d.pc = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, pc: '0, ir: '0};
        else        seq_q <= seq_d;
    end

    // tile fill datapath
    assign is_fill    = (seq_q.ir.opc == OP_FILL_S) || (seq_q.ir.opc == OP_FILL_R) ||
                        (seq_q.ir.opc == OP_FILL_C);
    assign is_fill_wr = is_fill || (seq_q.ir.opc == OP_MX_RES);
    assign fill_mode  = (seq_q.ir.opc == OP_FILL_R) ? FILL_ROW :
                        (seq_q.ir.opc == OP_FILL_C) ? FILL_COL : FILL_SCALAR;
    assign imm        = {seq_q.ir.fb, seq_q.ir.fc, seq_q.ir.fd, seq_q.ir.fe};
    assign imm_ext    = {{(ELEM_W-IMM_W){imm[IMM_W-1]}}, imm};

    tseq_bcast u_fill (
        .src     (rf_rd_data_a),
        .mode    (fill_mode),
        .row_idx (seq_q.ir.fc[ROW_IW-1:0]),
        .col_idx (seq_q.ir.fc[COL_IW-1:0]),
        .scalar  (imm_ext),
        .dst     (fill_tile)
    );

    tseq_mxu_track u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (mxu_start),
        .done   (mxu_done),
        .busy   (mx_busy)
    );

    // outputs
    assign imem_addr      = seq_q.pc;
    assign halted         = (seq_q.st == ST_HALT);

    assign sp_req_valid   = (seq_q.st == ST_SP_REQ);
    assign sp_req_write   = (seq_q.ir.opc == OP_STORE);
    assign sp_req_addr    = (seq_q.ir.opc == OP_STORE) ? seq_q.ir.fa : seq_q.ir.fb;
    assign sp_req_wdata   = rf_rd_data_a;

    assign rf_rd_addr_a   = seq_q.ir.fb;
    assign rf_rd_addr_b   = seq_q.ir.fc;
    assign rf_rd_addr_c   = seq_q.ir.fd;
    assign rf_wr_addr     = seq_q.ir.fa;
    assign rf_wr_en       = (seq_q.st == ST_SP_RSP) ||
                            ((seq_q.st == ST_VEC_RES) && vpu_rsp_valid) ||
                            ((seq_q.st == ST_EXEC) && is_fill_wr);

    always_comb begin
        if (seq_q.st == ST_SP_RSP)            rf_wr_data = sp_rsp_data;
        else if (seq_q.st == ST_VEC_RES)      rf_wr_data = vpu_rsp_data;
        else if (seq_q.ir.opc == OP_MX_RES)   rf_wr_data = mxu_result;
        else                                  rf_wr_data = fill_tile;
    end

    assign vpu_req_valid  = (seq_q.st == ST_VEC_EXEC);
    assign vpu_req_select = (seq_q.ir.opc == OP_SELECT);
    assign vpu_req_op     = seq_q.ir.fd;
    assign vpu_src_a      = rf_rd_data_a;
    assign vpu_src_b      = rf_rd_data_b;
    assign vpu_src_c      = rf_rd_data_c;

    assign mxu_start      = (seq_q.st == ST_EXEC) && (seq_q.ir.opc == OP_MX_GO);
    assign mxu_w_base     = seq_q.ir.fa;
    assign mxu_a_base     = seq_q.ir.fb;
    assign mxu_len        = seq_q.ir.fc;

    // assertions
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE) |-> (!sp_req_valid && !rf_wr_en && !vpu_req_valid && !mxu_start && !halted)); // R1
    AST_START_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (imem_addr == '0 && !halted));                                        // R2
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_FETCH && fetched.opc != OP_HALT && !start)
            |=> (imem_addr == $past(imem_addr) + 1'b1));                                // R2
    AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_req_valid && !sp_req_write && !start) |=> (rf_wr_en && rf_wr_addr == $past(seq_q.ir.fa))); // R3
    AST_STORE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_req_valid && sp_req_write && !start) |=> (!sp_req_valid && !rf_wr_en));     // R4
    AST_VEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        vpu_req_valid |=> !vpu_req_valid);                                              // R5
    AST_MXU_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mxu_start |=> !mxu_start);                                                      // R10
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WAIT && mx_busy && !mxu_done && !start) |=> (seq_q.st == ST_WAIT)); // R11
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> (halted && !rf_wr_en && !sp_req_valid && $stable(imem_addr))); // R13
endmodule

// File: tb/tb_tile_sequencer.sv
`timescale 1ns/1ps
module tb_tile_sequencer;
    import tseq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #4 clk = ~clk;

    logic [7:0]         imem_addr;
    logic [INSTR_W-1:0] imem_data;
    logic sp_req_valid, sp_req_write;
    logic [3:0] sp_req_addr;
    logic [TILE_W-1:0] sp_req_wdata, sp_rsp_data;
    logic [3:0] rf_rd_addr_a, rf_rd_addr_b, rf_rd_addr_c, rf_wr_addr;
    logic [TILE_W-1:0] rf_rd_data_a, rf_rd_data_b, rf_rd_data_c, rf_wr_data;
    logic rf_wr_en;
    logic vpu_req_valid, vpu_req_select;
    logic [3:0] vpu_req_op;
    logic [TILE_W-1:0] vpu_src_a, vpu_src_b, vpu_src_c;
    logic vpu_rsp_valid = 1'b0;
    logic [TILE_W-1:0] vpu_rsp_data = '0;
    logic mxu_start;
    logic [3:0] mxu_w_base, mxu_a_base, mxu_len;
    logic mxu_done = 1'b0;
    logic [TILE_W-1:0] mxu_result = '0;
    logic halted;

    int errors = 0;
    int checks = 0;

    tile_sequencer dut (.*);

    // ---------------- models ----------------
    logic [INSTR_W-1:0] prog [64];
    logic [TILE_W-1:0]  rf_m [16];
    logic [TILE_W-1:0]  sp_m [16];
    logic pl_rf = 1'b0, pl_sp = 1'b0;
    logic [3:0] pl_idx = '0;
    logic [TILE_W-1:0] pl_val = '0;
    int rf_writes = 0;

    assign imem_data    = prog[imem_addr[5:0]];
    assign rf_rd_data_a = rf_m[rf_rd_addr_a];
    assign rf_rd_data_b = rf_m[rf_rd_addr_b];
    assign rf_rd_data_c = rf_m[rf_rd_addr_c];

    logic [TILE_W-1:0] sp_rsp_q = '0;
    assign sp_rsp_data = sp_rsp_q;

    always @(posedge clk) begin
        if (rf_wr_en) begin
            rf_m[rf_wr_addr] <= rf_wr_data;
            rf_writes <= rf_writes + 1;
        end
        if (pl_rf) rf_m[pl_idx] <= pl_val;
        if (sp_req_valid) begin
            if (sp_req_write) sp_m[sp_req_addr] <= sp_req_wdata;
            else              sp_rsp_q <= sp_m[sp_req_addr];
        end
        if (pl_sp) sp_m[pl_idx] <= pl_val;
    end

    function automatic logic [31:0] el(input logic [TILE_W-1:0] t, input int i);
        return t[i*ELEM_W +: ELEM_W];
    endfunction

    function automatic logic [TILE_W-1:0] mk(input int seed);
        logic [TILE_W-1:0] t;
        for (int i = 0; i < 16; i++) t[i*ELEM_W +: ELEM_W] = 32'(seed * 37 - i * 5 + 3);
        return t;
    endfunction

    function automatic logic [TILE_W-1:0] vec_op(input logic sel, input logic [3:0] op,
            input logic [TILE_W-1:0] a, input logic [TILE_W-1:0] b, input logic [TILE_W-1:0] c);
        logic [TILE_W-1:0] t;
        for (int i = 0; i < 16; i++) begin
            if (sel)          t[i*ELEM_W +: ELEM_W] = (el(a, i) != 0) ? el(b, i) : el(c, i);
            else if (op == 0) t[i*ELEM_W +: ELEM_W] = el(a, i) + el(b, i);
            else if (op == 1) t[i*ELEM_W +: ELEM_W] = el(a, i) - el(b, i);
            else              t[i*ELEM_W +: ELEM_W] = el(a, i) ^ el(b, i);
        end
        return t;
    endfunction

    function automatic logic [TILE_W-1:0] mx_tile(input int w, input int a);
        logic [TILE_W-1:0] t;
        for (int i = 0; i < 16; i++) t[i*ELEM_W +: ELEM_W] = 32'(w * 1000 + a * 100 + i);
        return t;
    endfunction

    // vector unit stub: result two cycles after request
    logic vpu_pend = 1'b0;
    logic [TILE_W-1:0] vpu_hold = '0;
    always @(posedge clk) begin
        vpu_rsp_valid <= 1'b0;
        if (vpu_pend) begin
            vpu_rsp_valid <= 1'b1;
            vpu_rsp_data  <= vpu_hold;
            vpu_pend      <= 1'b0;
        end
        if (vpu_req_valid) begin
            vpu_pend <= 1'b1;
            vpu_hold <= vec_op(vpu_req_select, vpu_req_op, vpu_src_a, vpu_src_b, vpu_src_c);
        end
    end

    // matrix unit stub: latency equals the length field
    logic [4:0] mx_cnt = '0;
    int mx_cap_w = -1, mx_cap_a = -1, mx_starts = 0;
    always @(posedge clk) begin
        mxu_done <= 1'b0;
        if (mxu_start) begin
            mx_cnt     <= {1'b0, mxu_len};
            mxu_result <= mx_tile(int'(mxu_w_base), int'(mxu_a_base));
            mx_cap_w   <= int'(mxu_w_base);
            mx_cap_a   <= int'(mxu_a_base);
            mx_starts  <= mx_starts + 1;
        end else if (mx_cnt != 0) begin
            mx_cnt   <= mx_cnt - 1'b1;
            mxu_done <= (mx_cnt == 1);
        end
    end

    // ---------------- helpers ----------------
    function automatic logic [INSTR_W-1:0] enc(input int op, input int a, input int b,
                                               input int c, input int d);
        return {4'(op), 4'(a), 4'(b), 4'(c), 4'(d), 4'h0};
    endfunction

    function automatic logic [INSTR_W-1:0] enc_imm(input int op, input int a, input int imm);
        return {4'(op), 4'(a), 16'(imm)};
    endfunction

    task automatic chk_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_tile(input string req, input string what,
                            input logic [TILE_W-1:0] act, input logic [TILE_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = enc(10, 0, 0, 0, 0);
    endtask

    task automatic preload(input bit to_rf, input int idx, input logic [TILE_W-1:0] val);
        @(negedge clk);
        pl_rf  = to_rf;
        pl_sp  = !to_rf;
        pl_idx = 4'(idx);
        pl_val = val;
        @(negedge clk);
        pl_rf = 1'b0;
        pl_sp = 1'b0;
    endtask

    task automatic run(input int exp_cyc, input string req, input string what);
        int n = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!halted && n < 2000) begin
            n++;
            @(negedge clk);
        end
        chk_int(req, what, n, exp_cyc);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    logic [TILE_W-1:0] cond_t;
    logic [TILE_W-1:0] sum_t;

    initial begin
        clear_prog();
        // R1: reset state
        repeat (3) @(negedge clk);
        chk_int("R1", "halted in reset", int'(halted), 0);
        chk_int("R1", "requests in reset",
                int'({sp_req_valid, rf_wr_en, vpu_req_valid, mxu_start}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_int("R1", "idle after reset",
                int'({halted, sp_req_valid, rf_wr_en, vpu_req_valid, mxu_start}), 0);

        // ---------- program A: movement, vector ops, scalar fill, undefined ----------
        for (int i = 0; i < 16; i++) preload(1'b1, i, mk(100 + i));
        preload(1'b0, 3, mk(3));
        preload(1'b0, 5, mk(5));
        for (int i = 0; i < 16; i++) cond_t[i*ELEM_W +: ELEM_W] = (i % 3 == 0) ? 32'd0 : 32'(i + 1);
        preload(1'b1, 5, cond_t);
        sum_t = vec_op(1'b0, 4'd0, mk(3), mk(5), '0);
        clear_prog();
        prog[0] = enc(0, 1, 3, 0, 0);        // load r1 <- sp3
        prog[1] = enc(0, 2, 5, 0, 0);        // load r2 <- sp5
        prog[2] = enc(2, 3, 1, 2, 0);        // r3 = r1 + r2
        prog[3] = enc(2, 4, 1, 2, 1);        // r4 = r1 - r2
        prog[4] = enc(1, 7, 3, 0, 0);        // store sp7 <- r3
        prog[5] = enc(3, 6, 5, 1, 2);        // r6 = r5 ? r1 : r2
        prog[6] = enc_imm(4, 0, 16'hFFFB);   // r0 = -5
        prog[7] = enc(13, 7, 0, 0, 0);       // undefined opcode
        prog[8] = enc(0, 9, 7, 0, 0);        // load r9 <- sp7
        prog[9] = enc(10, 0, 0, 0, 0);       // halt
        run(3+3+4+4+2+4+2+1+3+1, "R2", "program A cycles");
        chk_tile("R3", "load r1", rf_m[1], mk(3));
        chk_tile("R3", "load r2", rf_m[2], mk(5));
        chk_tile("R5", "vector add r3", rf_m[3], sum_t);
        chk_tile("R5", "vector sub r4", rf_m[4], vec_op(1'b0, 4'd1, mk(3), mk(5), '0));
        chk_tile("R4", "store sp7", sp_m[7], sum_t);
        chk_tile("R6", "select r6", rf_m[6], vec_op(1'b1, 4'd0, cond_t, mk(3), mk(5)));
        chk_tile("R7", "scalar fill -5", rf_m[0], {16{32'hFFFF_FFFB}});
        chk_tile("R14", "undefined opcode leaves r7", rf_m[7], mk(107));
        chk_tile("R3", "reload of stored tile r9", rf_m[9], sum_t);
        chk_int("R2", "pc after halt", int'(imem_addr), 9);

        // R13: halted state holds with no writes
        begin
            int w0;
            w0 = rf_writes;
            repeat (6) @(negedge clk);
            chk_int("R13", "halted holds", int'(halted), 1);
            chk_int("R13", "no writes after halt", rf_writes - w0, 0);
            chk_int("R13", "pc frozen after halt", int'(imem_addr), 9);
        end

        // ---------- program B: row/column/scalar fill sweep ----------
        preload(1'b1, 1, mk(11));
        preload(1'b1, 2, mk(22));
        clear_prog();
        for (int k = 0; k < 4; k++) begin
            prog[2*k]   = enc(5, 8 + k, 1, k, 0);
            prog[2*k+1] = enc(6, 12 + k, 2, k, 0);
        end
        prog[8]  = enc_imm(4, 5, 16'h7FFF);
        prog[9]  = enc_imm(4, 6, 16'h8000);
        run(10*2+1, "R2", "program B cycles");
        for (int k = 0; k < 4; k++) begin
            logic [TILE_W-1:0] er, ec;
            for (int i = 0; i < 16; i++) begin
                er[i*ELEM_W +: ELEM_W] = el(mk(11), k*4 + (i % 4));
                ec[i*ELEM_W +: ELEM_W] = el(mk(22), (i / 4)*4 + k);
            end
            chk_tile("R8", $sformatf("row fill %0d", k), rf_m[8 + k], er);
            chk_tile("R9", $sformatf("col fill %0d", k), rf_m[12 + k], ec);
        end
        chk_tile("R7", "scalar fill max positive", rf_m[5], {16{32'h0000_7FFF}});
        chk_tile("R7", "scalar fill most negative", rf_m[6], {16{32'hFFFF_8000}});

        // ---------- program C: matrix dispatch / wait sweep ----------
        for (int nb = 0; nb < 3; nb++) begin
            for (int lat = 1; lat <= 6; lat++) begin
                int g, wc, s0, wb, ab;
                g  = 2 * nb;
                wc = (lat >= g + 1) ? (lat - g + 1) : 2;
                wb = (lat + nb) % 16;
                ab = (3 * lat + 1) % 16;
                clear_prog();
                prog[0] = enc(7, wb, ab, lat, 0);
                for (int j = 0; j < nb; j++) prog[1 + j] = enc_imm(4, 0, j + 1);
                prog[1 + nb] = enc(8, 0, 0, 0, 0);
                prog[2 + nb] = enc(9, 10, 0, 0, 0);
                s0 = mx_starts;
                run(2 + 2*nb + wc + 2 + 1, "R11",
                    $sformatf("wait cycles lat=%0d gap=%0d", lat, g));
                chk_int("R10", "one start pulse, fields carried",
                        (mx_starts - s0) * 10000 + mx_cap_w * 100 + mx_cap_a,
                        10000 + wb * 100 + ab);
                chk_tile("R12", $sformatf("result tile lat=%0d gap=%0d", lat, g),
                         rf_m[10], mx_tile(wb, ab));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule